// File: doc/BRIEF.md
# Eight-Channel Edge-Aligned PWM Timer

This peripheral drives eight pulse-width-modulated outputs from one shared 16-bit up-counter. The counter's time base is picked from three sources: every core clock, a fixed-rate tick input or an external tick input. A power-of-two prescaler then divides it. The counter runs from a programmable start value up to a programmable limit and then reloads. Each channel compares the running count with its own threshold. This gives an output that is high from the reload until the count reaches the threshold, and low for the rest of the period.

After the pulse is formed, each output can be inverted, or it can be forced to its idle level by a mask bit. While the counter is stopped, each channel drives a programmable start-up level instead of the waveform. Software programs the block through a plain 32-bit register port with a combinational read path. A configuration pin swaps the bytes of every data word so that a big-endian bus can use the block. Period and threshold writes are held in shadow registers and only move into the working copies at a period boundary, so a running waveform never shows a partial period.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads zero except the output mask at 0x60, which reads 0xFF, and all eight outputs are low.
- R2: Bits [4:3] of the control word at 0x00 pick the counting source: 0 stops the counter, 1 counts on every clock, 2 counts on cycles with `fix_tick_i` high, 3 counts on cycles with `ext_tick_i` high; the two unselected tick inputs have no effect.
- R3: Bits [2:0] of the control word give PS; the counter steps once every 2^PS source events.
- R4: The count (readable at 0x04) steps up by one and, on the step after it equals the limit at 0x08, reloads from the start value at 0x4C; a write to 0x04 loads the start value and clears the prescaler.
- R5: Channel n has a control word at 0x0C+8n and a threshold at 0x10+8n; with control bits 5 and 3 both set, the running output is high while count < threshold and low otherwise; with either bit clear it stays low.
- R6: A threshold of 0 keeps the output constantly low; a threshold above the limit keeps it constantly high.
- R7: Limit and threshold writes reach the working copies only at a counter reload (a write landing on the reload edge waits for the next reload); while the counter is stopped they take effect on the next clock.
- R8: Bit n of the polarity word at 0x70 inverts output n.
- R9: Bit n of the mask word at 0x60 forces output n to its idle level, which equals polarity bit n.
- R10: While the counter is stopped, an unmasked output n shows start-up bit n of 0x5C, XOR polarity bit n.
- R11: With `big_endian_i` high, the bytes of both the write data and the read data are reversed (byte 0 swaps with byte 3, byte 1 with byte 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian_i | input | 1 | Byte-reverse register data |
| fix_tick_i | input | 1 | Fixed-rate count enable |
| ext_tick_i | input | 1 | External count enable |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| pwm_o | output | 8 | Channel outputs |

## Verification
The main collision is a software write to a threshold that lands on the same edge where the counter wraps and the shadow copies are taken. The bench polls the count until it equals the limit and then issues the write, so it lands exactly on the reload edge. It then counts the high cycles in the next two periods: the first must still show the old threshold and the second the new one. A write that lands in the middle of a period is checked as well, and must not disturb the remainder of that period.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int NUM_CH_DEF = 8;
    localparam int CNT_W_DEF  = 16;
    localparam int PS_W_DEF   = 3;

    localparam logic [7:0] ADR_CTRL    = 8'h00;
    localparam logic [7:0] ADR_CNT     = 8'h04;
    localparam logic [7:0] ADR_LIMIT   = 8'h08;
    localparam logic [7:0] ADR_CH_BASE = 8'h0C;
    localparam logic [7:0] ADR_START   = 8'h4C;
    localparam logic [7:0] ADR_BOOT    = 8'h5C;
    localparam logic [7:0] ADR_MASK    = 8'h60;
    localparam logic [7:0] ADR_POL     = 8'h70;
    localparam int         CH_STRIDE   = 8;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } clk_src_e;

    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int PS_W  = PS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  clk_src_e         src_i,
    input  logic [PS_W-1:0]  ps_i,
    input  logic             fix_tick_i,
    input  logic             ext_tick_i,
    input  logic [CNT_W-1:0] limit_buf_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic             load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] limit_act_o,
    output logic             running_o,
    output logic             tick_o,
    output logic             update_o
);
    localparam int PSC_W = 1 << PS_W;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit_act;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic             src_en;
    logic [PSC_W-1:0] psc_lim;
    logic             wrap;

    always_comb begin
        unique case (src_i)
            SRC_SYS: src_en = 1'b1;
            SRC_FIX: src_en = fix_tick_i;
            SRC_EXT: src_en = ext_tick_i;
            default: src_en = 1'b0;
        endcase
        psc_lim   = (PSC_W'(1) << ps_i) - PSC_W'(1);
        tick_o    = src_en && (st_q.psc == psc_lim);
        wrap      = tick_o && (st_q.cnt >= st_q.limit_act);
        running_o = (src_i != SRC_OFF);
        update_o  = !running_o || wrap;

        st_d = st_q;
        if (src_en) begin
            st_d.psc = tick_o ? '0 : st_q.psc + PSC_W'(1);
        end
        if (tick_o) begin
            st_d.cnt = wrap ? start_i : st_q.cnt + CNT_W'(1);
        end
        if (update_o) begin
            st_d.limit_act = limit_buf_i;
        end
        if (load_i) begin
            st_d.cnt = start_i;
            st_d.psc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign limit_act_o = st_q.limit_act;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             pwm_en_i,
    input  logic             running_i,
    input  logic             boot_lvl_i,
    input  logic             invert_i,
    input  logic             masked_i,
    output logic             pwm_o
);
    logic raw;

    always_comb begin
        raw   = running_i ? (pwm_en_i && (cnt_i < thr_i)) : boot_lvl_i;
        pwm_o = masked_i ? invert_i : (raw ^ invert_i);
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int PS_W   = PS_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian_i,
    input  logic              fix_tick_i,
    input  logic              ext_tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [NUM_CH-1:0] pwm_o
);
    localparam int CTRL_W = 6;

    typedef struct packed {
        clk_src_e                              src;
        logic [PS_W-1:0]                       ps;
        logic [CNT_W-1:0]                      limit_buf;
        logic [CNT_W-1:0]                      start;
        logic [NUM_CH-1:0][CTRL_W-1:0]         ch_ctrl;
        logic [NUM_CH-1:0][CNT_W-1:0]          thr_buf;
        logic [NUM_CH-1:0][CNT_W-1:0]          thr_act;
        logic [NUM_CH-1:0]                     boot;
        logic [NUM_CH-1:0]                     mask;
        logic [NUM_CH-1:0]                     pol;
    } regs_t;

    regs_t reg_d, reg_q;

    logic [31:0]             wdata;
    logic [31:0]             rdata_raw;
    logic                    cnt_load;
    logic [CNT_W-1:0]        cnt_w;
    logic [CNT_W-1:0]        limit_act_w;
    logic                    running_w;
    logic                    tick_w;
    logic                    update_w;
    logic [NUM_CH-1:0][CNT_W-1:0] thr_act_w;
    logic [NUM_CH-1:0]       pwm_en_w;

    always_comb begin
        wdata    = big_endian_i ? swap32(bus_wdata_i) : bus_wdata_i;
        reg_d    = reg_q;
        cnt_load = 1'b0;

        if (update_w) begin
            reg_d.thr_act = reg_q.thr_buf;
        end

        if (bus_sel_i && bus_we_i) begin
            unique case (bus_addr_i)
                ADR_CTRL: begin
                    reg_d.src = clk_src_e'(wdata[4:3]);
                    reg_d.ps  = wdata[PS_W-1:0];
                end
                ADR_CNT:   cnt_load        = 1'b1;
                ADR_LIMIT: reg_d.limit_buf = wdata[CNT_W-1:0];
                ADR_START: reg_d.start     = wdata[CNT_W-1:0];
                ADR_BOOT:  reg_d.boot      = wdata[NUM_CH-1:0];
                ADR_MASK:  reg_d.mask      = wdata[NUM_CH-1:0];
                ADR_POL:   reg_d.pol       = wdata[NUM_CH-1:0];
                default: ;
            endcase
            for (int n = 0; n < NUM_CH; n++) begin
                if (bus_addr_i == ADR_CH_BASE + 8'(CH_STRIDE * n)) begin
                    reg_d.ch_ctrl[n] = wdata[CTRL_W-1:0];
                end
                if (bus_addr_i == ADR_CH_BASE + 8'(CH_STRIDE * n + 4)) begin
                    reg_d.thr_buf[n] = wdata[CNT_W-1:0];
                end
            end
        end

        rdata_raw = '0;
        unique case (bus_addr_i)
            ADR_CTRL:  rdata_raw = 32'({reg_q.src, reg_q.ps});
            ADR_CNT:   rdata_raw = 32'(cnt_w);
            ADR_LIMIT: rdata_raw = 32'(reg_q.limit_buf);
            ADR_START: rdata_raw = 32'(reg_q.start);
            ADR_BOOT:  rdata_raw = 32'(reg_q.boot);
            ADR_MASK:  rdata_raw = 32'(reg_q.mask);
            ADR_POL:   rdata_raw = 32'(reg_q.pol);
            default: ;
        endcase
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr_i == ADR_CH_BASE + 8'(CH_STRIDE * n)) begin
                rdata_raw = 32'(reg_q.ch_ctrl[n]);
            end
            if (bus_addr_i == ADR_CH_BASE + 8'(CH_STRIDE * n + 4)) begin
                rdata_raw = 32'(reg_q.thr_buf[n]);
            end
        end
        bus_rdata_o = big_endian_i ? swap32(rdata_raw) : rdata_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q      <= '0;
            reg_q.mask <= '1;
        end else begin
            reg_q <= reg_d;
        end
    end

    pwm_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (reg_q.src),
        .ps_i        (reg_q.ps),
        .fix_tick_i  (fix_tick_i),
        .ext_tick_i  (ext_tick_i),
        .limit_buf_i (reg_q.limit_buf),
        .start_i     (reg_q.start),
        .load_i      (cnt_load),
        .cnt_o       (cnt_w),
        .limit_act_o (limit_act_w),
        .running_o   (running_w),
        .tick_o      (tick_w),
        .update_o    (update_w)
    );

    assign thr_act_w = reg_q.thr_act;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign pwm_en_w[n] = reg_q.ch_ctrl[n][5] & reg_q.ch_ctrl[n][3];

        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .cnt_i      (cnt_w),
            .thr_i      (reg_q.thr_act[n]),
            .pwm_en_i   (pwm_en_w[n]),
            .running_i  (running_w),
            .boot_lvl_i (reg_q.boot[n]),
            .invert_i   (reg_q.pol[n]),
            .masked_i   (reg_q.mask[n]),
            .pwm_o      (pwm_o[n])
        );
    end

endmodule

// File: rtl/pwm_timer_sva.sv
module pwm_timer_sva #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cnt_load,
    input logic [CNT_W-1:0]             cnt,
    input logic [CNT_W-1:0]             limit_act,
    input logic [CNT_W-1:0]             start,
    input logic                         running,
    input logic                         tick,
    input logic [NUM_CH-1:0][CNT_W-1:0] thr_act,
    input logic [NUM_CH-1:0]            boot,
    input logic [NUM_CH-1:0]            mask,
    input logic [NUM_CH-1:0]            pol,
    input logic [NUM_CH-1:0]            pwm
);

    assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_load) |=> $stable(cnt));

    assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_load) |=> $stable(cnt));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt < limit_act) && !cnt_load) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt >= limit_act) && !cnt_load) |=> (cnt == $past(start)));

    assert_limit_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(tick && (cnt >= limit_act))) |=> $stable(limit_act));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
            mask[n] |-> (pwm[n] == pol[n]));

        assert_boot_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!running && !mask[n]) |-> (pwm[n] == (boot[n] ^ pol[n])));

        assert_zero_thr_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (running && !mask[n] && (thr_act[n] == '0)) |-> (pwm[n] == pol[n]));
    end

endmodule

bind pwm_timer pwm_timer_sva #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_load  (cnt_load),
    .cnt       (cnt_w),
    .limit_act (limit_act_w),
    .start     (reg_q.start),
    .running   (running_w),
    .tick      (tick_w),
    .thr_act   (thr_act_w),
    .boot      (reg_q.boot),
    .mask      (reg_q.mask),
    .pol       (reg_q.pol),
    .pwm       (pwm_o)
);

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;
    import pwm_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian_i = 1'b0;
    logic        fix_tick_i = 1'b0;
    logic        ext_tick_i = 1'b0;
    logic        bus_sel_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [7:0]  bus_addr_i = 8'h00;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [7:0]  pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i),
        .fix_tick_i(fix_tick_i), .ext_tick_i(ext_tick_i),
        .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pwm_o(pwm_o)
    );

    // limit, threshold, PS, expected high cycles over two periods
    localparam logic [50:0] VEC [0:5] = '{
        {16'd9,  16'd3,  3'd0, 16'd6},
        {16'd9,  16'd0,  3'd0, 16'd0},
        {16'd9,  16'd15, 3'd0, 16'd20},
        {16'd4,  16'd2,  3'd1, 16'd8},
        {16'd7,  16'd8,  3'd2, 16'd64},
        {16'd15, 16'd1,  3'd3, 16'd16}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel_i   = 1'b1;
        bus_we_i    = 1'b1;
        bus_addr_i  = a;
        bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0;
        bus_we_i  = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic count_high(input int cycles, output int highs);
        highs = 0;
        for (int k = 0; k < cycles; k++) begin
            if (pwm_o[0]) highs++;
            @(negedge clk);
        end
    endtask

    task automatic wait_cnt(input logic [31:0] target);
        logic [31:0] v;
        rd(ADR_CNT, v);
        while (v != target) begin
            @(negedge clk);
            rd(ADR_CNT, v);
        end
    endtask

    task automatic run_ch0(input logic [15:0] lim, input logic [15:0] thr,
                           input logic [2:0] ps, input logic [31:0] ctl);
        wr(ADR_CTRL, 32'h0);
        wr(ADR_CNT, 32'h0);
        wr(ADR_LIMIT, 32'(lim));
        wr(ADR_CH_BASE + 8'h04, 32'(thr));
        wr(ADR_CH_BASE, ctl);
        wr(ADR_MASK, 32'hFE);
        wr(ADR_CTRL, 32'h08 | 32'(ps));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs", 32'(pwm_o), 32'h0);
        rd(ADR_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        rd(ADR_MASK, v);  chk("R1 mask", v, 32'hFF);
        rd(ADR_LIMIT, v); chk("R1 limit", v, 32'h0);
        @(negedge clk);

        // R3 R5 R6 vector table
        for (int i = 0; i < 6; i++) begin
            logic [15:0] lim, thr, exp;
            logic [2:0]  ps;
            {lim, thr, ps, exp} = VEC[i];
            run_ch0(lim, thr, ps, 32'h28);
            count_high(2 * (int'(lim) + 1) * (1 << ps), highs);
            chk("R3/R5/R6 high cycles", 32'(highs), 32'(exp));
        end

        // R5 channel not fully in pulse mode stays low
        run_ch0(16'd9, 16'd5, 3'd0, 32'h20);
        count_high(20, highs);
        chk("R5 mode bit missing", 32'(highs), 32'd0);

        // R9 masked outputs show polarity
        wr(ADR_CTRL, 32'h0);
        wr(ADR_POL, 32'h02);
        wr(ADR_MASK, 32'hFF);
        chk("R9 masked level", 32'(pwm_o), 32'h02);

        // R8 inversion while running
        wr(ADR_POL, 32'h01);
        run_ch0(16'd9, 16'd3, 3'd0, 32'h28);
        count_high(20, highs);
        chk("R8 inverted high cycles", 32'(highs), 32'd14);

        // R10 boot level while stopped
        wr(ADR_CTRL, 32'h0);
        wr(ADR_POL, 32'h0);
        wr(ADR_BOOT, 32'h04);
        wr(ADR_MASK, 32'hFB);
        chk("R10 boot level", 32'(pwm_o), 32'h04);
        wr(ADR_BOOT, 32'h0);

        // R7 mid-period threshold write does not disturb current period
        run_ch0(16'd9, 16'd3, 3'd0, 32'h28);
        wait_cnt(32'd5);
        wr(ADR_CH_BASE + 8'h04, 32'd8);
        highs = 0;
        rd(ADR_CNT, v);
        while (v != 32'd0) begin
            if (pwm_o[0]) highs++;
            @(negedge clk);
            rd(ADR_CNT, v);
        end
        chk("R7 rest of period low", 32'(highs), 32'd0);
        count_high(10, highs);
        chk("R7 new threshold next period", 32'(highs), 32'd8);

        // R7 write landing on the reload edge waits one more period
        wait_cnt(32'd9);
        wr(ADR_CH_BASE + 8'h04, 32'd2);
        count_high(10, highs);
        chk("R7 coincident write deferred", 32'(highs), 32'd8);
        count_high(10, highs);
        chk("R7 coincident write applied", 32'(highs), 32'd2);

        // R4 start value reload
        wr(ADR_CTRL, 32'h0);
        wr(ADR_START, 32'd5);
        wr(ADR_LIMIT, 32'd7);
        wr(ADR_CNT, 32'h0);
        wr(ADR_CTRL, 32'h08);
        for (int k = 0; k < 6; k++) begin
            rd(ADR_CNT, v);
            chk("R4 count sequence", v, 32'(5 + (k % 3)));
            @(negedge clk);
        end
        wr(ADR_CTRL, 32'h0);
        wr(ADR_START, 32'd0);

        // R2 source selection
        wr(ADR_LIMIT, 32'd100);
        @(negedge clk);
        wr(ADR_CNT, 32'h0);
        wr(ADR_CTRL, 32'h10);
        for (int k = 0; k < 10; k++) begin
            fix_tick_i = (k % 2) == 1;
            @(negedge clk);
        end
        fix_tick_i = 1'b0;
        rd(ADR_CNT, v); chk("R2 fixed tick count", v, 32'd5);
        ext_tick_i = 1'b1;
        repeat (4) @(negedge clk);
        ext_tick_i = 1'b0;
        rd(ADR_CNT, v); chk("R2 external ignored", v, 32'd5);
        wr(ADR_CTRL, 32'h18);
        ext_tick_i = 1'b1;
        repeat (3) @(negedge clk);
        ext_tick_i = 1'b0;
        rd(ADR_CNT, v); chk("R2 external count", v, 32'd8);
        wr(ADR_CTRL, 32'h0);
        fix_tick_i = 1'b1;
        ext_tick_i = 1'b1;
        repeat (3) @(negedge clk);
        fix_tick_i = 1'b0;
        ext_tick_i = 1'b0;
        rd(ADR_CNT, v); chk("R2 stopped", v, 32'd8);

        // R11 byte order
        big_endian_i = 1'b1;
        wr(ADR_LIMIT, 32'h3412_0000);
        rd(ADR_LIMIT, v); chk("R11 big-endian read", v, 32'h3412_0000);
        big_endian_i = 1'b0;
        rd(ADR_LIMIT, v); chk("R11 native read", v, 32'h0000_1234);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule